// File: doc/BRIEF.md
# Slot Interrupt-Pin Routing Register File

This block stores the routing that ties each device slot's four legacy interrupt pins (INTA to INTD, encoded 0 to 3) to one of eight shared interrupt lines, PIRQ A to H, encoded 0 to 7. A range of slots has a programmable 16-bit routing word. Each word sits in a small byte-addressed window that software reaches through a little-endian read/write port. The port accepts byte lengths of 1, 2 or 4.

A second port is a registered lookup. An interrupt fabric presents a slot number and a pin, and one clock later it receives the 3-bit PIRQ index for that pair. One slot inside the programmable range is a bridge slot. Its register reads as zero and ignores writes, and its pins are always routed to PIRQ E to H. Slots outside the programmable range use a fixed rotating formula that never selects PIRQ A to D. Every write to the window raises a one-cycle change pulse, so the consumer knows to re-evaluate its routes.

Top module: `pirq_route_regs`

## Requirements
- R1: After reset, every programmable routing word holds DEF_WORD (default 16'h7654). The bridge slot's word and every byte of the window not covered by a routing word read as zero.
- R2: For a programmable slot, pin p uses the 4-bit field at word bits [4p+3:4p]. The low 3 bits of that field are the PIRQ index, and bit 3 is ignored.
- R3: The bridge slot (HARD_SLOT, default 30) reads as zero, and writes to it have no effect. Its lookup returns pin+4, so INTA to INTD map to PIRQ E to H.
- R4: A slot with no routing word returns ((slot + pin) mod 4) + 4 for pin p.
- R5: An access address is reduced to its low log2(WIN_BYTES) bits before use. The window defaults to 16 bytes, so addresses 0x13 and 0x03 reach the same byte.
- R6: An access that would run past the end of the window is shortened to the bytes that remain. Bytes beyond the end are not written, the access does not wrap to offset 0, and the dropped read lanes return zero.
- R7: Data is little-endian. Byte lane j, at wdata/rdata bits [8j+7:8j], goes to or comes from window offset base+j.
- R8: The routing word for slot FIRST_SLOT+k (default slot 25+k) occupies offsets 2k (low byte) and 2k+1 (high byte).
- R9: `routeChg` is high for exactly the cycle after each clock edge that accepts a write, including a write whose bytes all land on read-only locations. A read never raises it.
- R10: `lkPirq` is registered. It reflects the slot, the pin and the register contents present at the previous clock edge. `rdata` and `rdValid` appear one cycle after the edge that accepts `rdEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write request for this cycle |
| rdEn | input | 1 | Read request for this cycle |
| addr | input | ADDR_W | Byte address, masked to the window size |
| len | input | 3 | Access length in bytes: 1, 2 or 4 |
| wdata | input | 32 | Write data, little-endian lanes |
| rdata | output | 32 | Read data, held until the next read |
| rdValid | output | 1 | High the cycle after a read is accepted |
| routeChg | output | 1 | One-cycle pulse after each write |
| lkSlot | input | SLOT_W | Lookup slot number |
| lkPin | input | 2 | Lookup pin: 0 = INTA through 3 = INTD |
| lkPirq | output | 3 | Registered PIRQ index: 0 = A through 7 = H |

## Verification
The checker follows the cycle-level contracts on every clock. It checks that the change pulse appears after writes and only after writes, that read data arrives one cycle after a read, and that an access starting at the last window byte returns zero in its upper lanes. It also checks that bridge-slot and unprogrammed-slot lookups always land in PIRQ E to H with the right index. The checker cannot follow stored contents, so the directed scenarios cover them. These scenarios show the reset defaults and the field decode with the ignored top bit. They also show lane ordering, address masking, write clamping without wrap-around, the bridge slot refusing writes, and the extra cycle before a newly written route shows up at the lookup.

// File: rtl/pirq_route_pkg.sv
package pirq_route_pkg;

  localparam int LANES   = 4;   // byte lanes on the 32-bit data bus
  localparam int FIELD_W = 4;   // bits reserved per pin in a routing word
  localparam int SEL_W   = 3;   // bits of a field that select the PIRQ

  // strobes from access control to the storage datapath
  typedef struct packed {
    logic             wrStb;
    logic             rdStb;
    logic [LANES-1:0] laneEn;
  } accCtrl_t;

endpackage

// File: rtl/rr_access_ctrl.sv
module rr_access_ctrl
  import pirq_route_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WIN_BYTES = 16,
  localparam int OFF_W    = $clog2(WIN_BYTES)
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        len,
  output accCtrl_t          ctrl,
  output logic [OFF_W-1:0]  baseOff
);

  localparam logic [OFF_W:0] WIN_L = (OFF_W+1)'(WIN_BYTES);

  logic [OFF_W:0] room;
  logic [2:0]     lenCap;
  logic [2:0]     effLen;
  logic           unusedAddrHi;

  assign unusedAddrHi = ^addr[ADDR_W-1:OFF_W];

  // window-relative offset: upper address bits are discarded
  assign baseOff = addr[OFF_W-1:0];
  assign room    = WIN_L - {1'b0, baseOff};

  always_comb begin
    lenCap = (len > 3'd4) ? 3'd4 : len;
    // shorten when the access reaches the window end
    if ({{(OFF_W-2){1'b0}}, lenCap} >= room) effLen = room[2:0];
    else                                      effLen = lenCap;
  end

  always_comb begin
    ctrl.wrStb = wrEn;
    ctrl.rdStb = rdEn;
    for (int j = 0; j < LANES; j++) begin
      ctrl.laneEn[j] = (3'(j) < effLen);
    end
  end

endmodule

// File: rtl/rr_route_store.sv
module rr_route_store
  import pirq_route_pkg::*;
#(
  parameter int          WIN_BYTES  = 16,
  parameter int          FIRST_SLOT = 25,
  parameter int          NUM_WORDS  = 7,
  parameter int          HARD_SLOT  = 30,
  parameter int          SLOT_W     = 5,
  parameter logic [15:0] DEF_WORD   = 16'h7654,
  localparam int OFF_W   = $clog2(WIN_BYTES),
  localparam int HARD_IX = HARD_SLOT - FIRST_SLOT
) (
  input  logic              clk,
  input  logic              rstN,
  input  accCtrl_t          ctrl,
  input  logic [OFF_W-1:0]  baseOff,
  input  logic [31:0]       wdata,
  input  logic [SLOT_W-1:0] lkSlot,
  input  logic [1:0]        lkPin,
  output logic [31:0]       rdata,
  output logic              rdValid,
  output logic              routeChg,
  output logic [2:0]        lkPirq
);

  logic [7:0]  cfgByte [WIN_BYTES];
  logic [15:0] wordArr [NUM_WORDS];
  logic [31:0] rdNext;
  logic [2:0]  lkNext;
  int          slotI;
  int          pinI;

  // ---------------- byte storage ----------------
  for (genvar b = 0; b < WIN_BYTES; b++) begin : gByte
    localparam bit IN_WORD = (b < 2*NUM_WORDS);
    localparam bit IS_HARD = IN_WORD && ((b / 2) == HARD_IX);
    localparam logic [7:0] RST_V =
      (IN_WORD && !IS_HARD) ? DEF_WORD[8*(b%2) +: 8] : 8'h00;

    if (IS_HARD) begin : gFixed
      assign cfgByte[b] = 8'h00;
    end else begin : gReg
      logic [7:0] q;
      logic       hit;
      logic [7:0] hitData;

      always_comb begin
        hit     = 1'b0;
        hitData = 8'h00;
        for (int j = 0; j < LANES; j++) begin
          if (ctrl.wrStb && ctrl.laneEn[j] &&
              (({1'b0, baseOff} + (OFF_W+1)'(j)) == (OFF_W+1)'(b))) begin
            hit     = 1'b1;
            hitData = wdata[8*j +: 8];
          end
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN)    q <= RST_V;
        else if (hit) q <= hitData;
      end

      assign cfgByte[b] = q;
    end
  end

  for (genvar k = 0; k < NUM_WORDS; k++) begin : gWord
    assign wordArr[k] = {cfgByte[2*k+1], cfgByte[2*k]};
  end

  // ---------------- read path ----------------
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      rdNext[8*j +: 8] = ctrl.laneEn[j] ? cfgByte[baseOff + OFF_W'(j)] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata    <= '0;
      rdValid  <= 1'b0;
      routeChg <= 1'b0;
    end else begin
      rdValid  <= ctrl.rdStb;
      routeChg <= ctrl.wrStb;
      if (ctrl.rdStb) rdata <= rdNext;
    end
  end

  // ---------------- routing lookup ----------------
  always_comb begin
    slotI  = int'(lkSlot);
    pinI   = int'(lkPin);
    lkNext = {1'b1, lkSlot[1:0] + lkPin};           // rotating default, E..H
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (slotI == FIRST_SLOT + k) lkNext = wordArr[k][pinI*FIELD_W +: SEL_W];
    end
    if (slotI == HARD_SLOT) lkNext = {1'b1, lkPin}; // bridge slot, fixed E..H
  end

  always_ff @(posedge clk) begin
    if (!rstN) lkPirq <= 3'd0;
    else       lkPirq <= lkNext;
  end

endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_route_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          WIN_BYTES  = 16,
  parameter int          FIRST_SLOT = 25,
  parameter int          NUM_WORDS  = 7,
  parameter int          HARD_SLOT  = 30,
  parameter int          SLOT_W     = 5,
  parameter logic [15:0] DEF_WORD   = 16'h7654
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        len,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rdValid,
  output logic              routeChg,
  input  logic [SLOT_W-1:0] lkSlot,
  input  logic [1:0]        lkPin,
  output logic [2:0]        lkPirq
);

  localparam int OFF_W = $clog2(WIN_BYTES);

  accCtrl_t         ctrl;
  logic [OFF_W-1:0] baseOff;

  rr_access_ctrl #(
    .ADDR_W    (ADDR_W),
    .WIN_BYTES (WIN_BYTES)
  ) uCtrl (
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .len     (len),
    .ctrl    (ctrl),
    .baseOff (baseOff)
  );

  rr_route_store #(
    .WIN_BYTES  (WIN_BYTES),
    .FIRST_SLOT (FIRST_SLOT),
    .NUM_WORDS  (NUM_WORDS),
    .HARD_SLOT  (HARD_SLOT),
    .SLOT_W     (SLOT_W),
    .DEF_WORD   (DEF_WORD)
  ) uStore (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .baseOff  (baseOff),
    .wdata    (wdata),
    .lkSlot   (lkSlot),
    .lkPin    (lkPin),
    .rdata    (rdata),
    .rdValid  (rdValid),
    .routeChg (routeChg),
    .lkPirq   (lkPirq)
  );

endmodule

// File: rtl/pirq_route_chk.sv
module pirq_route_chk #(
  parameter int WIN_BYTES  = 16,
  parameter int FIRST_SLOT = 25,
  parameter int NUM_WORDS  = 7,
  parameter int HARD_SLOT  = 30,
  parameter int SLOT_W     = 5,
  localparam int OFF_W     = $clog2(WIN_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [OFF_W-1:0]  addrLo,
  input logic [23:0]       rdataHi,
  input logic              rdValid,
  input logic              routeChg,
  input logic [SLOT_W-1:0] lkSlot,
  input logic [1:0]        lkPin,
  input logic [2:0]        lkPirq
);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R9: a write edge is followed by the change pulse
  a_r9_pulse_on_write: assert property (@(posedge clk) disable iff (!rstN || !armed)
    wrEn |=> routeChg);

  // R9: no pulse without a write
  a_r9_quiet_without_write: assert property (@(posedge clk) disable iff (!rstN || !armed)
    !wrEn |=> !routeChg);

  // R10: read data is valid exactly one cycle after the request
  a_r10_read_latency: assert property (@(posedge clk) disable iff (!rstN || !armed)
    rdEn |=> rdValid);

  // R6: a read starting at the last byte returns only lane 0
  a_r6_clamped_lanes_zero: assert property (@(posedge clk) disable iff (!rstN || !armed)
    ($past(rdEn) && ($past(addrLo) == OFF_W'(WIN_BYTES-1))) |-> (rdataHi == 24'h0));

  // R3: bridge slot maps pin p to PIRQ p+4
  a_r3_hard_slot: assert property (@(posedge clk) disable iff (!rstN || !armed)
    ($past(lkSlot) == SLOT_W'(HARD_SLOT)) |-> (lkPirq == {1'b1, $past(lkPin)}));

  // R4: slots without a word rotate within PIRQ E..H
  a_r4_rotating_default: assert property (@(posedge clk) disable iff (!rstN || !armed)
    ((int'($past(lkSlot)) < FIRST_SLOT) || (int'($past(lkSlot)) >= FIRST_SLOT + NUM_WORDS))
      |-> (lkPirq == {1'b1, 2'($past(lkSlot[1:0]) + $past(lkPin))}));

endmodule

bind pirq_route_regs pirq_route_chk #(
  .WIN_BYTES  (WIN_BYTES),
  .FIRST_SLOT (FIRST_SLOT),
  .NUM_WORDS  (NUM_WORDS),
  .HARD_SLOT  (HARD_SLOT),
  .SLOT_W     (SLOT_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .addrLo   (addr[$clog2(WIN_BYTES)-1:0]),
  .rdataHi  (rdata[31:8]),
  .rdValid  (rdValid),
  .routeChg (routeChg),
  .lkSlot   (lkSlot),
  .lkPin    (lkPin),
  .lkPirq   (lkPirq)
);

// File: tb/sim_pirq_route_regs.sv
`timescale 1ns/1ps
module sim_pirq_route_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [2:0]  len = 3'd1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rdValid;
  logic        routeChg;
  logic [4:0]  lkSlot = '0;
  logic [1:0]  lkPin = '0;
  logic [2:0]  lkPirq;

  int nTests = 0;
  int nFail  = 0;
  logic [31:0] v;

  always #2 clk = ~clk;   // 250 MHz

  pirq_route_regs u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .len(len),
    .wdata(wdata), .rdata(rdata), .rdValid(rdValid), .routeChg(routeChg),
    .lkSlot(lkSlot), .lkPin(lkPin), .lkPirq(lkPirq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrAcc(input logic [7:0] a, input logic [2:0] l, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; len = l; wdata = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdAcc(input logic [7:0] a, input logic [2:0] l, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a; len = l;
    @(negedge clk); rdEn = 1'b0; d = rdata;
  endtask

  task automatic look(input logic [4:0] s, input logic [1:0] p, output logic [31:0] r);
    @(negedge clk); lkSlot = s; lkPin = p;
    @(negedge clk); r = {29'd0, lkPirq};
  endtask

  task automatic doReset;
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tReset;
    chk("R1 routeChg idle", {31'd0, routeChg}, 32'd0);
    rdAcc(8'h00, 3'd2, v); chk("R1 slot25 default", v, 32'h7654);
    rdAcc(8'h0C, 3'd2, v); chk("R1 R8 slot31 default", v, 32'h7654);
    rdAcc(8'h0A, 3'd2, v); chk("R1 bridge word zero", v, 32'h0);
    rdAcc(8'h0E, 3'd2, v); chk("R1 spare bytes zero", v, 32'h0);
  endtask

  task automatic tDefaultLookup;
    look(5'd25, 2'd0, v); chk("R2 slot25 INTA", v, 32'd4);
    look(5'd25, 2'd3, v); chk("R2 slot25 INTD", v, 32'd7);
    look(5'd31, 2'd2, v); chk("R2 slot31 INTC", v, 32'd6);
  endtask

  task automatic tFieldDecode;
    wrAcc(8'h02, 3'd2, 32'h0000_08F1);
    look(5'd26, 2'd0, v); chk("R2 field 1", v, 32'd1);
    look(5'd26, 2'd1, v); chk("R2 field F top bit ignored", v, 32'd7);
    look(5'd26, 2'd2, v); chk("R2 field 8 top bit ignored", v, 32'd0);
    look(5'd26, 2'd3, v); chk("R2 field 0", v, 32'd0);
  endtask

  task automatic tEndian;
    wrAcc(8'h04, 3'd4, 32'h1122_3344);
    rdAcc(8'h05, 3'd1, v); chk("R7 lane1 at base+1", v, 32'h33);
    rdAcc(8'h04, 3'd2, v); chk("R7 halfword order", v, 32'h3344);
    look(5'd27, 2'd1, v); chk("R7 R8 slot27 INTB", v, 32'd4);
    look(5'd28, 2'd0, v); chk("R7 R8 slot28 INTA", v, 32'd2);
  endtask

  task automatic tMask;
    wrAcc(8'h13, 3'd1, 32'h0000_00A5);
    rdAcc(8'h03, 3'd1, v); chk("R5 masked write", v, 32'hA5);
    rdAcc(8'h23, 3'd1, v); chk("R5 masked read", v, 32'hA5);
    look(5'd26, 2'd3, v); chk("R5 slot26 INTD", v, 32'd2);
  endtask

  task automatic tClamp;
    wrAcc(8'h0E, 3'd4, 32'hDDCC_BBAA);
    rdAcc(8'h00, 3'd2, v); chk("R6 no wrap on write", v, 32'h7654);
    rdAcc(8'h0E, 3'd4, v); chk("R6 read clamp 2", v, 32'h0000_BBAA);
    rdAcc(8'h0F, 3'd4, v); chk("R6 read clamp 1", v, 32'h0000_00BB);
    wrAcc(8'h0D, 3'd4, 32'h0403_0201);
    rdAcc(8'h0C, 3'd4, v); chk("R6 write clamp 3", v, 32'h0302_0154);
    look(5'd31, 2'd2, v); chk("R6 slot31 INTC", v, 32'd1);
  endtask

  task automatic tHardSlot;
    wrAcc(8'h0A, 3'd2, 32'h0000_FFFF);
    rdAcc(8'h0A, 3'd2, v); chk("R3 bridge write ignored", v, 32'h0);
    wrAcc(8'h08, 3'd4, 32'hFFFF_FFFF);
    rdAcc(8'h08, 3'd4, v); chk("R3 neighbour written bridge kept", v, 32'h0000_FFFF);
    look(5'd30, 2'd0, v); chk("R3 bridge INTA", v, 32'd4);
    look(5'd30, 2'd3, v); chk("R3 bridge INTD", v, 32'd7);
  endtask

  task automatic tFormula;
    look(5'd0,  2'd0, v); chk("R4 slot0 INTA", v, 32'd4);
    look(5'd3,  2'd2, v); chk("R4 slot3 INTC", v, 32'd5);
    look(5'd24, 2'd3, v); chk("R4 slot24 INTD", v, 32'd7);
    look(5'd13, 2'd1, v); chk("R4 slot13 INTB", v, 32'd6);
  endtask

  task automatic tPulseAndLatency;
    // lookup held on slot27 INTA (word 0x3344 -> 4) while rewriting it
    @(negedge clk); lkSlot = 5'd27; lkPin = 2'd0;
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h04; len = 3'd2; wdata = 32'h0000_0003;
    @(negedge clk); wrEn = 1'b0;
    chk("R9 pulse after write", {31'd0, routeChg}, 32'd1);
    chk("R10 lookup still old", {29'd0, lkPirq}, 32'd4);
    @(negedge clk);
    chk("R9 pulse one cycle", {31'd0, routeChg}, 32'd0);
    chk("R10 lookup updated", {29'd0, lkPirq}, 32'd3);
    @(negedge clk); rdEn = 1'b1; addr = 8'h04; len = 3'd1;
    @(negedge clk); rdEn = 1'b0;
    chk("R9 no pulse on read", {31'd0, routeChg}, 32'd0);
    chk("R10 rdValid after read", {31'd0, rdValid}, 32'd1);
    chk("R10 read data", rdata, 32'h03);
    @(negedge clk);
    chk("R10 rdValid one cycle", {31'd0, rdValid}, 32'd0);
  endtask

  task automatic tReReset;
    doReset();
    rdAcc(8'h02, 3'd2, v); chk("R1 default restored", v, 32'h7654);
    rdAcc(8'h0E, 3'd2, v); chk("R1 spare cleared", v, 32'h0);
  endtask

  initial begin
    #(4 * 100000);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tDefaultLookup();
    tFieldDecode();
    tEndian();
    tMask();
    tClamp();
    tHardSlot();
    tFormula();
    tPulseAndLatency();
    tReReset();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule